// File: doc/BRIEF.md
# Delayed Serial Sample Relay

This block sits on a three-wire serial sample link that carries stereo sub-band samples. A word-select line runs at the sample rate, and a bit clock runs at 64 times that rate. A frame-sync strobe marks the word period that holds sub-band 0. The block deserialises each 24-bit sample and stores it in a circular buffer. It sends the sample out again a fixed number of word-select periods later, using the same framing on a second data pin. The relayed stream therefore stays aligned with results that a neighbouring unit computes over the same span.

Both data pins are bidirectional, and the block reaches each one through a split pad (input, output, output enable). The direction bit is captured when an external reset line falls, and it selects one of two modes. In encode mode the block listens on pin A and drives pin B, with the long delay. In decode mode it listens on pin B and drives pin A, with the short delay. The processing reset forces decode mode. Storage starts at the first word period flagged by frame-sync. The driving pin stays released until a whole delay's worth of samples has been stored, so the first word transmitted is the first word stored.

Top module: `subband_delay_relay`

## Requirements
- R1: Each word-select half period has 32 bit-clock slots. Slot 0 is the slot in which the bit clock's rising edge first sees a new word-select level. A 24-bit sample occupies slots 1 to 24, most significant bit in slot 1. The left channel is carried while word-select is 0 and the right channel while it is 1. The transmitted stream uses the same slots, with its data changing only after bit-clock falling edges.
- R2: In encode mode (direction bit 0), samples are taken from pin A and appear on pin B exactly ENC_DELAY word-select periods later (default 480), in the same channel.
- R3: In decode mode (direction bit 1), samples are taken from pin B and appear on pin A exactly DEC_DELAY word-select periods later (default 160).
- R4: The direction bit is sampled only when the external reset falls, and changes on it at any other time have no effect. While the external reset is high, neither pin is driven.
- R5: The processing reset releases both pins and selects decode mode without any external reset edge.
- R6: Storage begins at the word-select falling transition during which frame-sync is high. Earlier samples are discarded. The output enable rises at the transition that starts the half period exactly one delay after that point.
- R7: Input bits in slot 0 and slots 25 to 31 are ignored, as is any data on the pin not selected for input. The transmitter drives 0 in slots 25 to 31.
- R8: At most one pin output enable is active, and the enabled one is the transmit pin for the current mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high processing reset, selects decode mode |
| ext_rst | input | 1 | External reset; datapath cleared while high, direction latched on its fall |
| dir_in | input | 1 | Direction bit: 0 encode, 1 decode |
| ws | input | 1 | Word select, 0 = left, 1 = right |
| bclk | input | 1 | Serial bit clock, 64 per word-select period |
| fsync | input | 1 | Frame-sync strobe marking the sub-band 0 word period |
| a_i | input | 1 | Pin A pad input |
| b_i | input | 1 | Pin B pad input |
| a_o | output | 1 | Pin A pad output data |
| a_oe | output | 1 | Pin A pad output enable |
| b_o | output | 1 | Pin B pad output data |
| b_oe | output | 1 | Pin B pad output enable |

## Verification
Every half period carries a distinct 24-bit word computed arithmetically from its index. The unused slots are filled with ones, and the pin that is not listened to carries the complement of the data. A wrong slot, a wrong bit order, a wrong source pin or a leak of unused bits therefore all show up as a data mismatch. The bench starts each stream a few halves before the first frame-sync. This separates a buffer that starts on the strobe from one that starts on the first edge seen. The bench checks both the data and the enable timing against the expected delay, in each mode. It reaches each mode through the external reset edge, through the processing reset, and with the direction bit toggled during a run. This distinguishes a correctly latched direction from one that follows the pin.

// File: rtl/subband_delay_relay.sv
module subband_delay_relay #(
  parameter int SAMPLE_W  = 24,
  parameter int SLOTS     = 32,
  parameter int ENC_DELAY = 480,
  parameter int DEC_DELAY = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst,
  input  logic dir_in,
  input  logic ws,
  input  logic bclk,
  input  logic fsync,
  input  logic a_i,
  input  logic b_i,
  output logic a_o,
  output logic a_oe,
  output logic b_o,
  output logic b_oe
);
  localparam int MAX_D = (ENC_DELAY > DEC_DELAY) ? ENC_DELAY : DEC_DELAY;
  localparam int DEPTH = 2 * MAX_D;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = $clog2(DEPTH + 1);
  localparam int CW    = $clog2(SLOTS) + 1;

  logic mode, ext_q, bclk_q, primed, started, en, ws_prev, tx_bit;
  logic [CW-1:0] cnt, pos;
  logic [SAMPLE_W-1:0] rx_sr, tx_sr;
  logic [AW-1:0] ptr, ptr_n;
  logic [FW-1:0] fill, len;
  logic [SAMPLE_W-1:0] mem [DEPTH];

  wire hold    = rst | ext_rst;
  wire rise    = bclk & ~bclk_q;
  wire fall    = ~bclk & bclk_q;
  wire din     = mode ? b_i : a_i;
  wire ws_edge = primed && (ws != ws_prev);
  wire go      = started || (ws_edge && !ws && fsync);
  wire capture = rise && started && (pos == CW'(SAMPLE_W));

  assign pos   = ws_edge ? '0 : ((&cnt) ? cnt : cnt + CW'(1));
  assign len   = mode ? FW'(2 * DEC_DELAY) : FW'(2 * ENC_DELAY);
  assign ptr_n = !started ? '0 : ((FW'(ptr) + FW'(1) == len) ? '0 : ptr + AW'(1));

  assign a_o  = tx_bit;
  assign b_o  = tx_bit;
  assign a_oe = en & mode;
  assign b_oe = en & ~mode;

  always_ff @(posedge clk) begin
    ext_q <= rst ? 1'b0 : ext_rst;
    if (rst)                   mode <= 1'b1;
    else if (ext_q && !ext_rst) mode <= dir_in;
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      bclk_q <= 1'b0; primed <= 1'b0; started <= 1'b0; en <= 1'b0;
      ws_prev <= 1'b0; cnt <= '0; ptr <= '0; fill <= '0;
      rx_sr <= '0; tx_sr <= '0; tx_bit <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (rise) begin
        primed  <= 1'b1;
        ws_prev <= ws;
        cnt     <= pos;
        if (pos != '0 && pos <= CW'(SAMPLE_W)) rx_sr <= {rx_sr[SAMPLE_W-2:0], din};
        if (ws_edge && go) begin
          started <= 1'b1;
          ptr     <= ptr_n;
          tx_sr   <= mem[ptr_n];
          en      <= (fill == len);
        end
        if (capture && fill != len) fill <= fill + FW'(1);
      end
      if (fall) begin
        if (cnt < CW'(SAMPLE_W)) begin
          tx_bit <= tx_sr[SAMPLE_W-1];
          tx_sr  <= {tx_sr[SAMPLE_W-2:0], 1'b0};
        end else begin
          tx_bit <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (!hold && capture) mem[ptr] <= {rx_sr[SAMPLE_W-2:0], din};

  // R4
  mode_latch_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode) |-> $past(ext_q && !ext_rst));

  // R8
  oe_mode_chk: assert property (@(posedge clk) disable iff (hold)
    (a_oe || b_oe) |-> $stable(mode));

  // R6
  en_full_chk: assert property (@(posedge clk) disable iff (hold)
    $rose(en) |-> (fill == len));

  // R1
  tx_fall_chk: assert property (@(posedge clk) disable iff (hold)
    !$stable(tx_bit) |-> $past(fall));

  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (hold)
    started |-> (FW'(ptr) < len));
endmodule

// File: tb/subband_delay_relay_tb.sv
module subband_delay_relay_tb_top;
  localparam int ENC = 4;
  localparam int DEC = 2;

  logic clk = 1'b0;
  logic rst, ext_rst, dir_in, ws, bclk, fsync, a_i, b_i;
  logic a_o, a_oe, b_o, b_oe;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  subband_delay_relay #(.ENC_DELAY(ENC), .DEC_DELAY(DEC)) dut_i (
    .clk(clk), .rst(rst), .ext_rst(ext_rst), .dir_in(dir_in), .ws(ws),
    .bclk(bclk), .fsync(fsync), .a_i(a_i), .b_i(b_i),
    .a_o(a_o), .a_oe(a_oe), .b_o(b_o), .b_oe(b_oe));

  function automatic logic [23:0] val(input int h);
    logic [31:0] t;
    t = (32'(h + 1000) * 32'h0001_3579) ^ 32'h00C3_A55A;
    return t[23:0];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_half(input int h, input bit md, input int d);
    logic [23:0] word, got;
    bit oe_seen, other_bad, junk_bad;
    word = val(h);
    got = '0; oe_seen = 0; other_bad = 0; junk_bad = 0;
    for (int s = 0; s < 32; s++) begin
      bit db;
      db = (s >= 1 && s <= 24) ? word[24 - s] : 1'b1;
      ws = h[0];
      fsync = (h >= 0) && (h % 64 == 0);
      if (md) begin b_i = db; a_i = ~db; end
      else    begin a_i = db; b_i = ~db; end
      bclk = 1'b0;
      tick(2);
      if (md ? b_oe : a_oe) other_bad = 1;
      if (s >= 1 && s <= 24) got = {got[22:0], md ? a_o : b_o};
      if (s == 1) oe_seen = md ? a_oe : b_oe;
      if (s > 24 && (md ? a_oe : b_oe) && (md ? a_o : b_o)) junk_bad = 1;
      bclk = 1'b1;
      tick(2);
    end
    check(oe_seen == (h >= 2 * d), "R6", int'(oe_seen), int'(h >= 2 * d));
    check(!other_bad, "R8", int'(other_bad), 0);
    if (h >= 2 * d) begin
      check(got == val(h - 2 * d), md ? "R1 R3" : "R1 R2", int'(got), int'(val(h - 2 * d)));
      check(!junk_bad, "R7", int'(junk_bad), 0);
    end
  endtask

  task automatic run_stream(input bit md, input int d, input int pre, input int n, input bit toggle);
    for (int h = -pre; h < n; h++) begin
      if (toggle && h == 1) dir_in = ~dir_in;  // R4: ignored mid-run
      send_half(h, md, d);
    end
  endtask

  task automatic ext_pulse(input bit dv);
    dir_in = dv;
    ext_rst = 1'b1;
    tick(3);
    check(!a_oe && !b_oe, "R4", int'({a_oe, b_oe}), 0);
    ext_rst = 1'b0;
    tick(1);
    dir_in = ~dv;
  endtask

  initial begin
    rst = 1'b1; ext_rst = 1'b0; dir_in = 1'b0; bclk = 1'b0;
    ws = 1'b0; fsync = 1'b0; a_i = 1'b0; b_i = 1'b0;
    tick(6);
    check(!a_oe && !b_oe, "R5", int'({a_oe, b_oe}), 0);
    rst = 1'b0;
    tick(2);
    // R5: decode after processing reset, no external edge
    run_stream(1'b1, DEC, 2, 2 * DEC + 4, 1'b1);
    // R2: encode through external reset edge
    ext_pulse(1'b0);
    run_stream(1'b0, ENC, 2, 2 * ENC + 4, 1'b1);
    // R3: decode through external reset edge
    ext_pulse(1'b1);
    run_stream(1'b1, DEC, 4, 2 * DEC + 4, 1'b0);
    // R5: processing reset overrides a latched encode mode
    ext_pulse(1'b0);
    run_stream(1'b0, ENC, 0, 4, 1'b0);
    rst = 1'b1;
    tick(6);
    check(!a_oe && !b_oe, "R5", int'({a_oe, b_oe}), 0);
    rst = 1'b0;
    tick(2);
    run_stream(1'b1, DEC, 2, 2 * DEC + 3, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule